// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns 32-bit virtual addresses from a processor into physical addresses using 4 KB pages. A small, fully associative translation cache answers repeated requests without touching memory. On a miss, a hardware walker reads two entries from memory through a single word-wide port. It first reads a directory entry selected by the upper ten address bits, then a leaf entry selected by the next ten bits. It then answers with either the translated address or a page fault.

Whenever a translation succeeds, the walker keeps the usage bits of the leaf entry up to date. It always sets the referenced bit, and on a store it also sets the modified bit. The entry is written back to memory only when one of these bits actually changes. A store that hits a cached entry still marked clean is sent through the full walk, so that memory learns of the modification.

The processor side accepts one request at a time with a valid/ready handshake and holds each response until it is taken. The memory side issues one-cycle read or write requests and waits any number of cycles for the matching response pulse. Writes are acknowledged with a response pulse too. A flush input invalidates every cached translation.

Top module: `xlate_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: The first read of a walk is at `ptbase + 4*vaddr[31:22]`, and every memory request lasts exactly one cycle.
- R3: The second read of a walk is at `{dir_entry[31:12], vaddr[21:12], 2'b00}`.
- R4: A successful response gives `rsp_paddr = {leaf[31:12], vaddr[11:0]}` with `rsp_fault` 0.
- R5: A translation already cached (and, for a store, cached as modified) answers with no memory request.
- R6: A directory entry with bit 0 clear gives `rsp_fault`=1, `rsp_fault_lvl`=0 and `rsp_fault_vaddr` equal to the request address, after exactly one memory read.
- R7: A leaf entry with bit 0 clear gives `rsp_fault`=1 and `rsp_fault_lvl`=1, after exactly two reads.
- R8: A load sets bit 5 (referenced) of the leaf entry with one write-back. It writes nothing when bit 5 is already set.
- R9: A store sets both bit 5 and bit 6 (modified) of the leaf entry with one write-back.
- R10: A store that hits a cached entry whose modified bit is clear repeats both reads and writes bit 6 to memory.
- R11: The cache holds 8 translations and replaces them in round-robin order. After 8 further distinct pages are filled, the oldest is gone and the second oldest still hits.
- R12: A one-cycle pulse on `flush` invalidates every cached translation.
- R13: `req_ready` is 0 from the acceptance of a request until its response is taken, and no memory request is made while a response is pending.
- R14: While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays valid and unchanged.

Entry encoding used throughout: bit 0 valid, bit 5 referenced, bit 6 modified, bits 31:12 frame number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptbase | input | 32 | Byte address of the page directory |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | Request is for a store |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 1 | Page fault |
| rsp_fault_lvl | output | 1 | Fault level: 0 directory, 1 leaf |
| rsp_fault_vaddr | output | 32 | Virtual address of the request |
| mem_req_valid | output | 1 | One-cycle memory request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Word address in bytes |
| mem_req_wdata | output | 32 | Data to write |
| mem_rsp_valid | input | 1 | Memory response or write acknowledge |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
The hardest condition to reach from the ports is a replacement decision. It depends on the hidden round-robin pointer and on which slots are still live after a flush. The stimulus flushes the cache and refills it with one page plus eight more distinct pages, so the pointer has wrapped exactly once whatever its starting value. It then tells eviction from retention only by counting memory reads on two later lookups. The store-on-clean-hit case is reached by loading a page first, so that it is cached clean, and then storing to it. The memory model varies its latency from request to request.

// File: rtl/xw_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the translation walker.
// Assumes 32-bit addresses, 4 KB pages and 4-byte table entries.
package xw_pkg;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int PN_W   = ADDR_W - OFF_W;
    localparam int BIT_V     = 0;
    localparam int BIT_REF   = 5;
    localparam int BIT_DIRTY = 6;

    typedef logic [PN_W-1:0] pn_t;

    typedef enum logic [3:0] {
        S_IDLE, S_LOOK, S_DREQ, S_DWAIT, S_TREQ, S_TWAIT, S_WREQ, S_WWAIT, S_RESP
    } walk_st_t;
endpackage

// File: rtl/xw_tlb.sv
`timescale 1ns/1ps
// Fully associative translation cache with round-robin replacement.
// Looks up lk_vpn every cycle. A fill overwrites the entry that matches
// lk_vpn if there is one, otherwise the round-robin slot. A flush wins over a fill.
module xw_tlb
    import xw_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  pn_t  lk_vpn,
    output logic hit,
    output pn_t  hit_pfn,
    output logic hit_dirty,
    input  logic fill_en,
    input  pn_t  fill_pfn,
    input  logic fill_dirty
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] dty_q;
    logic [ENTRIES-1:0] match;
    pn_t                vpn_q [ENTRIES];
    pn_t                pfn_q [ENTRIES];
    logic [IW-1:0]      hit_idx;
    logic [IW-1:0]      rr_q;
    logic [IW-1:0]      slot;

    // Compare the lookup page against every entry in parallel.
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = vld_q[g] && (vpn_q[g] == lk_vpn);
        end
    endgenerate

    // Encode the matching slot and select its contents.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_idx = IW'(i);
        end
        hit       = |match;
        hit_pfn   = pfn_q[hit_idx];
        hit_dirty = dty_q[hit_idx];
        slot      = hit ? hit_idx : rr_q;
    end

    // Flush, install entries and advance the replacement pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            dty_q <= '0;
            rr_q  <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i] <= '0;
                pfn_q[i] <= '0;
            end
        end else if (flush) begin
            vld_q <= '0;
        end else if (fill_en) begin
            vld_q[slot] <= 1'b1;
            dty_q[slot] <= fill_dirty;
            vpn_q[slot] <= lk_vpn;
            pfn_q[slot] <= fill_pfn;
            if (!hit) begin
                rr_q <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + IW'(1);
            end
        end
    end
endmodule

// File: rtl/xw_walk.sv
`timescale 1ns/1ps
// Walk controller: accepts a request, consults the translation cache and,
// on a miss, reads the directory and leaf entries. It writes the leaf back
// when its usage bits change, fills the cache and holds the response.
// Assumes memory answers every request, including writes, with one
// mem_rsp_valid pulse, and never answers without a request.
module xw_walk
    import xw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ptbase,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_store,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_fault,
    output logic              rsp_fault_lvl,
    output logic [ADDR_W-1:0] rsp_fault_vaddr,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [ADDR_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_rdata,
    output pn_t               lk_vpn,
    input  logic              tlb_hit,
    input  pn_t               tlb_pfn,
    input  logic              tlb_dirty,
    output logic              fill_en,
    output pn_t               fill_pfn,
    output logic              fill_dirty
);
    walk_st_t          state_q;
    logic [ADDR_W-1:0] va_q;
    logic              st_q;
    pn_t               tbase_q;
    logic [ADDR_W-1:0] leaf_q;
    logic [ADDR_W-1:0] paddr_q;
    logic              fault_q;
    logic              lvl_q;
    logic [ADDR_W-1:0] set_mask;
    logic [ADDR_W-1:0] leaf_new;
    logic              leaf_changes;

    // Leaf entry with the usage bits this access requires.
    always_comb begin
        set_mask            = '0;
        set_mask[BIT_REF]   = 1'b1;
        set_mask[BIT_DIRTY] = st_q;
        leaf_new            = mem_rsp_rdata | set_mask;
        leaf_changes        = (leaf_new != mem_rsp_rdata);
    end

    // Drive handshake, memory port and cache fill from the state.
    always_comb begin
        req_ready       = (state_q == S_IDLE);
        rsp_valid       = (state_q == S_RESP);
        rsp_paddr       = paddr_q;
        rsp_fault       = fault_q;
        rsp_fault_lvl   = lvl_q;
        rsp_fault_vaddr = va_q;
        mem_req_valid   = (state_q == S_DREQ) || (state_q == S_TREQ) || (state_q == S_WREQ);
        mem_req_write   = (state_q == S_WREQ);
        mem_req_wdata   = leaf_q;
        if (state_q == S_DREQ) begin
            mem_req_addr = ptbase + {{(ADDR_W - IDX_W - 2){1'b0}}, va_q[ADDR_W-1 -: IDX_W], 2'b00};
        end else begin
            mem_req_addr = {tbase_q, va_q[OFF_W +: IDX_W], 2'b00};
        end
        lk_vpn  = va_q[ADDR_W-1:OFF_W];
        fill_en = mem_rsp_valid &&
                  (((state_q == S_TWAIT) && mem_rsp_rdata[BIT_V] && !leaf_changes) ||
                   (state_q == S_WWAIT));
        if (state_q == S_WWAIT) begin
            fill_pfn   = leaf_q[ADDR_W-1:OFF_W];
            fill_dirty = leaf_q[BIT_DIRTY];
        end else begin
            fill_pfn   = mem_rsp_rdata[ADDR_W-1:OFF_W];
            fill_dirty = mem_rsp_rdata[BIT_DIRTY];
        end
    end

    // Sequence one translation from acceptance to response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            va_q    <= '0;
            st_q    <= 1'b0;
            tbase_q <= '0;
            leaf_q  <= '0;
            paddr_q <= '0;
            fault_q <= 1'b0;
            lvl_q   <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        st_q    <= req_store;
                        state_q <= S_LOOK;
                    end
                end
                S_LOOK: begin
                    if (tlb_hit && (tlb_dirty || !st_q)) begin
                        paddr_q <= {tlb_pfn, va_q[OFF_W-1:0]};
                        fault_q <= 1'b0;
                        state_q <= S_RESP;
                    end else begin
                        state_q <= S_DREQ;
                    end
                end
                S_DREQ: state_q <= S_DWAIT;
                S_DWAIT: begin
                    if (mem_rsp_valid) begin
                        if (!mem_rsp_rdata[BIT_V]) begin
                            fault_q <= 1'b1;
                            lvl_q   <= 1'b0;
                            paddr_q <= '0;
                            state_q <= S_RESP;
                        end else begin
                            tbase_q <= mem_rsp_rdata[ADDR_W-1:OFF_W];
                            state_q <= S_TREQ;
                        end
                    end
                end
                S_TREQ: state_q <= S_TWAIT;
                S_TWAIT: begin
                    if (mem_rsp_valid) begin
                        if (!mem_rsp_rdata[BIT_V]) begin
                            fault_q <= 1'b1;
                            lvl_q   <= 1'b1;
                            paddr_q <= '0;
                            state_q <= S_RESP;
                        end else begin
                            fault_q <= 1'b0;
                            paddr_q <= {mem_rsp_rdata[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};
                            leaf_q  <= leaf_new;
                            state_q <= leaf_changes ? S_WREQ : S_RESP;
                        end
                    end
                end
                S_WREQ: state_q <= S_WWAIT;
                S_WWAIT: begin
                    if (mem_rsp_valid) state_q <= S_RESP;
                end
                S_RESP: begin
                    if (rsp_ready) state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xlate_walker.sv
`timescale 1ns/1ps
// Top of the translation walker: the walk controller plus the translation cache.
// Assumes ptbase is stable while a walk is in progress.
module xlate_walker
    import xw_pkg::*;
#(
    parameter int TLB_ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ptbase,
    input  logic        flush,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic        req_store,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [31:0] rsp_paddr,
    output logic        rsp_fault,
    output logic        rsp_fault_lvl,
    output logic [31:0] rsp_fault_vaddr,
    output logic        mem_req_valid,
    output logic        mem_req_write,
    output logic [31:0] mem_req_addr,
    output logic [31:0] mem_req_wdata,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_rdata
);
    pn_t  lk_vpn;
    logic tlb_hit;
    pn_t  tlb_pfn;
    logic tlb_dirty;
    logic fill_en;
    pn_t  fill_pfn;
    logic fill_dirty;

    xw_walk walk_i (
        .clk(clk), .rst_n(rst_n), .ptbase(ptbase),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_store(req_store),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .rsp_fault_lvl(rsp_fault_lvl), .rsp_fault_vaddr(rsp_fault_vaddr),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .lk_vpn(lk_vpn), .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn), .tlb_dirty(tlb_dirty),
        .fill_en(fill_en), .fill_pfn(fill_pfn), .fill_dirty(fill_dirty)
    );

    xw_tlb #(.ENTRIES(TLB_ENTRIES)) tlb_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_vpn(lk_vpn),
        .hit(tlb_hit), .hit_pfn(tlb_pfn), .hit_dirty(tlb_dirty),
        .fill_en(fill_en), .fill_pfn(fill_pfn), .fill_dirty(fill_dirty)
    );
endmodule

// File: rtl/xw_checker.sv
`timescale 1ns/1ps
// Protocol and data checks on the walker's ports, bound to xlate_walker.
// Keeps its own copy of the accepted address to check the responses.
module xw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_paddr,
    input logic        rsp_fault,
    input logic [31:0] rsp_fault_vaddr,
    input logic        mem_req_valid,
    input logic        mem_req_write,
    input logic [1:0]  wr_flags
);
    logic [31:0] va_cap;

    // Capture the address of each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                      va_cap <= '0;
        else if (req_valid && req_ready) va_cap <= req_vaddr;
    end

    a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    a_r4_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[11:0] == va_cap[11:0]));

    a_r6_fault_va: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_fault_vaddr == va_cap));

    a_r8_wb_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (wr_flags == 2'b11));

    a_r13_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!req_ready && !mem_req_valid));

    a_r14_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));
endmodule

bind xlate_walker xw_checker chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_fault_vaddr(rsp_fault_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .wr_flags({mem_req_wdata[5], mem_req_wdata[0]})
);

// File: tb/xlate_walker_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected responses, a monitor pops and compares.
module xlate_walker_tb_top;
    localparam logic [31:0] PTB  = 32'h0010_0000;
    localparam logic [31:0] TBLS = 32'h0020_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ptbase = PTB;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_store = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        rsp_fault_lvl;
    logic [31:0] rsp_fault_vaddr;
    logic        mem_req_valid;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;

    always #10 clk = ~clk;

    xlate_walker dut_i (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Memory model with latency rotating between 1 and 3 cycles.
    logic [31:0] pmem [logic [31:0]];
    logic [31:0] rd_log [$];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          lat_cnt = 0;
    int          lsel = 0;
    logic [31:0] pend_addr = '0;

    function automatic logic [31:0] rdm(logic [31:0] a);
        return pmem.exists(a) ? pmem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_rdata <= '0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid) begin
                pend_addr = mem_req_addr;
                if (mem_req_write) begin
                    pmem[mem_req_addr] = mem_req_wdata;
                    wr_cnt++;
                end else begin
                    rd_cnt++;
                    rd_log.push_back(mem_req_addr);
                end
                lat_cnt = 1 + lsel;
                lsel = (lsel + 1) % 3;
            end else if (lat_cnt > 0) begin
                lat_cnt--;
                if (lat_cnt == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_rdata <= rdm(pend_addr);
                end
            end
        end
    end

    // Reference walk and page-table setup.
    typedef struct packed {
        logic        f;
        logic        l;
        logic [31:0] pa;
        logic [31:0] va;
    } exp_t;

    function automatic exp_t ref_walk(logic [31:0] va);
        exp_t e;
        logic [31:0] d;
        logic [31:0] t;
        e.va = va; e.f = 1'b0; e.l = 1'b0; e.pa = '0;
        d = rdm(PTB + {20'd0, va[31:22], 2'b00});
        if (!d[0]) begin e.f = 1'b1; return e; end
        t = rdm({d[31:12], va[21:12], 2'b00});
        if (!t[0]) begin e.f = 1'b1; e.l = 1'b1; return e; end
        e.pa = {t[31:12], va[11:0]};
        return e;
    endfunction

    function automatic logic [31:0] leaf_addr(logic [31:0] va);
        return TBLS + {va[31:22], 12'h000} + {20'd0, va[21:12], 2'b00};
    endfunction

    task automatic map(logic [31:0] va, logic [19:0] pfn, logic [11:0] flags);
        pmem[PTB + {20'd0, va[31:22], 2'b00}] = (TBLS + {va[31:22], 12'h000}) | 32'h1;
        pmem[leaf_addr(va)] = {pfn, flags};
    endtask

    // Monitor: pop the expected item and compare it with each response taken.
    exp_t expq [$];
    int   resp_cnt = 0;

    always @(negedge clk) begin : mon
        exp_t e;
        if (rst_n && rsp_valid && rsp_ready) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R13 unexpected response", rsp_paddr, 32'h0);
            end else begin
                e = expq.pop_front();
                chk(rsp_fault == e.f, "R6 R7 fault flag", {31'd0, rsp_fault}, {31'd0, e.f});
                if (e.f) begin
                    chk(rsp_fault_lvl == e.l, "R7 fault level", {31'd0, rsp_fault_lvl}, {31'd0, e.l});
                    chk(rsp_fault_vaddr == e.va, "R6 fault vaddr", rsp_fault_vaddr, e.va);
                end else begin
                    chk(rsp_paddr == e.pa, "R4 paddr", rsp_paddr, e.pa);
                end
            end
            resp_cnt++;
        end
    end

    // Driver: push the expectation, issue the request, check memory traffic.
    task automatic xlate(logic [31:0] va, bit st, int exp_rd, int exp_wr, string rq);
        int r0;
        int w0;
        int tgt;
        expq.push_back(ref_walk(va));
        r0 = rd_cnt; w0 = wr_cnt; tgt = resp_cnt + 1;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_store = st;
        @(negedge clk);
        req_valid = 1'b0;
        wait (resp_cnt == tgt);
        @(negedge clk);
        chk(rd_cnt - r0 == exp_rd, {rq, " reads"}, 32'(rd_cnt - r0), 32'(exp_rd));
        chk(wr_cnt - w0 == exp_wr, {rq, " writes"}, 32'(wr_cnt - w0), 32'(exp_wr));
    endtask

    localparam logic [31:0] VA_A  = {10'd1, 10'd2, 12'h345};
    localparam logic [31:0] VA_B  = {10'd1, 10'd3, 12'h010};
    localparam logic [31:0] VA_DF = {10'd5, 10'd0, 12'h777};
    localparam logic [31:0] VA_TF = {10'd1, 10'd7, 12'h0AA};
    localparam logic [31:0] VA_C  = {10'd3, 10'd0, 12'h004};

    logic [31:0] held_pa;
    int          tgt2;

    initial begin
        map(VA_A, 20'h12345, 12'h001);
        map(VA_B, 20'h0ABCD, 12'h021);
        map(VA_TF, 20'h00000, 12'h000);
        map(VA_C, 20'h77777, 12'h001);
        for (int i = 0; i < 8; i++) begin
            map({10'd2, 10'(i), 12'h100}, 20'h40000 + 20'(i), 12'h021);
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 req_ready", {31'd0, req_ready}, 32'd1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);

        // R2 R3 R4 R8: first walk for a load.
        rd_log.delete();
        xlate(VA_A, 1'b0, 2, 1, "R8 load walk");
        chk(rd_log[0] == PTB + 32'h4, "R2 directory read address", rd_log[0], PTB + 32'h4);
        chk(rd_log[1] == 32'h0020_1008, "R3 leaf read address", rd_log[1], 32'h0020_1008);
        chk(rdm(leaf_addr(VA_A)) == 32'h1234_5021, "R8 referenced bit", rdm(leaf_addr(VA_A)), 32'h1234_5021);

        // R5: cached load.
        xlate(VA_A, 1'b0, 0, 0, "R5 load hit");
        // R10: store to a clean cached entry.
        xlate(VA_A, 1'b1, 2, 1, "R10 store on clean hit");
        chk(rdm(leaf_addr(VA_A)) == 32'h1234_5061, "R10 dirty in memory", rdm(leaf_addr(VA_A)), 32'h1234_5061);
        // R5: store to an entry cached as modified.
        xlate(VA_A, 1'b1, 0, 0, "R5 store hit");
        // R8: referenced bit already set, no write-back.
        xlate(VA_B, 1'b0, 2, 0, "R8 no write when set");
        // R6 and R7: faults at both levels.
        xlate(VA_DF, 1'b0, 1, 0, "R6 directory fault");
        xlate(VA_TF, 1'b1, 2, 0, "R7 leaf fault");
        // R9: fresh store.
        xlate(VA_C, 1'b1, 2, 1, "R9 store walk");
        chk(rdm(leaf_addr(VA_C)) == 32'h7777_7061, "R9 both bits", rdm(leaf_addr(VA_C)), 32'h7777_7061);

        // R13 R14: hold the response back.
        rsp_ready = 1'b0;
        expq.push_back(ref_walk(VA_C));
        tgt2 = resp_cnt + 1;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = VA_C; req_store = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R13 busy after accept", {31'd0, req_ready}, 32'd0);
        while (!rsp_valid) @(negedge clk);
        held_pa = rsp_paddr;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(rsp_valid == 1'b1, "R14 valid held", {31'd0, rsp_valid}, 32'd1);
            chk(rsp_paddr == held_pa, "R14 paddr held", rsp_paddr, held_pa);
            chk(req_ready == 1'b0, "R13 not ready while pending", {31'd0, req_ready}, 32'd0);
        end
        rsp_ready = 1'b1;
        wait (resp_cnt == tgt2);
        @(negedge clk);

        // R12: flush forces a new walk.
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        xlate(VA_A, 1'b0, 2, 0, "R12 walk after flush");

        // R11: eight more pages wrap the replacement pointer once.
        for (int i = 0; i < 8; i++) begin
            xlate({10'd2, 10'(i), 12'h100}, 1'b0, 2, 0, "R11 fill");
        end
        xlate({10'd2, 10'd0, 12'h100}, 1'b0, 0, 0, "R11 second oldest kept");
        xlate(VA_A, 1'b0, 2, 0, "R11 oldest evicted");

        chk(expq.size() == 0, "R13 all responses seen", 32'(expq.size()), 32'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R13 watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule